// File: doc/BRIEF.md
# Pixel Output Formatter

The formatter takes one pixel per clock from a display pipeline (three 12-bit components plus a data-enable) and turns it into the word a parallel display port expects. On the way it can exchange the red and blue inputs and put the three components in any of six orders. It clamps the luma and chroma positions into separate programmable windows. It can pack a luma sample and an alternating chroma sample into one beat, and it places each component on a 16-bit output lane at 8, 10, 12 or 16 bits of depth.

All settings are static inputs. They are copied into the block only while the soft-reset input is high. While that input is high the pipeline is flushed and the output stays idle. Normal formatting resumes the cycle after the input goes low, with a fixed two-cycle latency from input to output, and the data-enable follows the data through the same two cycles.

Top module: `pixel_out_formatter`

## Requirements
- R1: After the synchronous active-low reset, out_de and out_data are zero, and the held settings are: bottom limits 0x010, top limits 0xFE0 (luma and chroma), input swap off, order RGB, mapping RGB, depth 8 bits.
- R2: out_de equals pix_de from two clock edges earlier. While out_de is low, out_data is all zero.
- R3: The setting inputs are captured only on edges where soft_rst is high. Changes to them while soft_rst is low have no effect. The edge after soft_rst is sampled high, out_de is low.
- R4: Input component positions are R = pix_data[35:24], G = [23:12], B = [11:0]. When input swap is on, R and B are exchanged before reordering.
- R5: Order code on the output lanes (lane 2 = out_data[47:32], lane 1 = [31:16], lane 0 = [15:0]), listed top to bottom: 0 RGB, 1 GBR, 2 BRG, 3 RBG, 4 GRB, 5 BGR. Codes 6 and 7 act as RGB.
- R6: Format code 0 (and 3) uses the swap and order inputs as given. Code 1 (4:4:4 YCbCr) forces swap off and order BGR. Code 2 (4:2:2 YCbCr) forces swap on and order RGB.
- R7: After reordering, lane 1 is clamped into [luma bottom, luma top], and lanes 2 and 0 into [chroma bottom, chroma top].
- R8: Mapping code 0 is RGB, which passes the three lanes through unchanged. Codes 1 (CYCY) and 3 (CY) give {chroma, luma, 0} across lanes 2..0. Codes 2 (YCYC) and 4 (YC) give {luma, chroma, 0}. Codes 5 to 7 act as RGB. Luma is clamped lane 1.
- R9: Pixel parity is even on the first beat after any cycle with pix_de low and alternates on each following beat. In codes 1 and 2, chroma is clamped lane 0 on even beats and lane 2 on odd beats. In codes 3 and 4 it is lane 2 on even beats and lane 0 on odd beats.
- R10: Depth code 0 puts component bits [11:4] in lane bits [7:0]. Code 1 puts [11:2] in [9:0], code 2 puts [11:0] in [11:0], and code 3 puts the component in [15:4] with the low four bits zero. Codes 4 to 7 act as 8 bits. All other lane bits are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| soft_rst | input | 1 | High: capture settings and hold output idle |
| cfg_fmt | input | 2 | Colour format code |
| cfg_in_swap | input | 1 | Red/blue input exchange |
| cfg_order | input | 3 | Output component order code |
| cfg_map | input | 3 | Luma/chroma mapping code |
| cfg_depth | input | 3 | Output depth code |
| cfg_y_lo | input | 12 | Luma bottom limit |
| cfg_y_hi | input | 12 | Luma top limit |
| cfg_c_lo | input | 12 | Chroma bottom limit |
| cfg_c_hi | input | 12 | Chroma top limit |
| pix_de | input | 1 | Input data-enable |
| pix_data | input | 36 | Input pixel {R,G,B} |
| out_de | output | 1 | Output data-enable |
| out_data | output | 48 | Output lanes {lane2,lane1,lane0} |

## Verification
Several properties are checked on every cycle: the two-cycle data-enable delay, the zero data on blank cycles, the idle output after a soft reset, the settings holding while soft reset is low, the clamp windows, parity restarting and alternating, the zero pad lane in packed modes, and the empty upper bits at 8-bit depth. Only the bench's scenarios can show that each order, format override, chroma phase and depth places the right component bits in the right lane. The same holds for the fallback of unlisted codes and for the settings being ignored when they change outside soft reset.

// File: rtl/pof_pkg.sv
// Shared widths, codes and the settings record for the pixel output formatter.
package pof_pkg;
    parameter int COMP_W  = 12;
    parameter int LANE_W  = 16;
    parameter int N_LANES = 3;
    localparam int PIX_W  = N_LANES * COMP_W;
    localparam int OUT_W  = N_LANES * LANE_W;

    typedef enum logic [1:0] {FMT_RGB = 2'd0, FMT_YUV444 = 2'd1, FMT_YUV422 = 2'd2, FMT_RSVD = 2'd3} fmt_e;
    typedef enum logic [2:0] {ORD_RGB = 3'd0, ORD_GBR = 3'd1, ORD_BRG = 3'd2,
                              ORD_RBG = 3'd3, ORD_GRB = 3'd4, ORD_BGR = 3'd5} order_e;
    typedef enum logic [2:0] {MAP_RGB = 3'd0, MAP_CYCY = 3'd1, MAP_YCYC = 3'd2,
                              MAP_CY = 3'd3, MAP_YC = 3'd4} map_e;
    typedef enum logic [2:0] {DEP_8 = 3'd0, DEP_10 = 3'd1, DEP_12 = 3'd2, DEP_16 = 3'd3} depth_e;

    localparam logic [COMP_W-1:0] LIM_BOT_RST = COMP_W'(12'h010);
    localparam logic [COMP_W-1:0] LIM_TOP_RST = COMP_W'(12'hFE0);

    typedef struct packed {
        logic              in_swap;
        order_e            order;
        map_e              map;
        depth_e            depth;
        logic [COMP_W-1:0] y_lo;
        logic [COMP_W-1:0] y_hi;
        logic [COMP_W-1:0] c_lo;
        logic [COMP_W-1:0] c_hi;
    } fmt_cfg_t;

    function automatic fmt_cfg_t cfg_default();
        fmt_cfg_t c;
        c.in_swap = 1'b0;
        c.order   = ORD_RGB;
        c.map     = MAP_RGB;
        c.depth   = DEP_8;
        c.y_lo    = LIM_BOT_RST;
        c.y_hi    = LIM_TOP_RST;
        c.c_lo    = LIM_BOT_RST;
        c.c_hi    = LIM_TOP_RST;
        return c;
    endfunction
endpackage

// File: rtl/pof_cfg.sv
// Settings capture. Decodes the raw setting inputs, folds the colour-format
// overrides into swap/order, and loads the result only while soft_rst is high.
// Assumes the raw inputs are static outside soft reset; unlisted codes fall back.
module pof_cfg
    import pof_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              soft_rst,
    input  logic [1:0]        cfg_fmt,
    input  logic              cfg_in_swap,
    input  logic [2:0]        cfg_order,
    input  logic [2:0]        cfg_map,
    input  logic [2:0]        cfg_depth,
    input  logic [COMP_W-1:0] cfg_y_lo,
    input  logic [COMP_W-1:0] cfg_y_hi,
    input  logic [COMP_W-1:0] cfg_c_lo,
    input  logic [COMP_W-1:0] cfg_c_hi,
    output fmt_cfg_t          cfg_q
);
    fmt_cfg_t cfg_d;

    // Decode raw codes into legal settings and apply format overrides.
    always_comb begin
        cfg_d.y_lo = cfg_y_lo;
        cfg_d.y_hi = cfg_y_hi;
        cfg_d.c_lo = cfg_c_lo;
        cfg_d.c_hi = cfg_c_hi;
        case (cfg_order)
            3'd0, 3'd1, 3'd2, 3'd3, 3'd4, 3'd5: cfg_d.order = order_e'(cfg_order);
            default:                            cfg_d.order = ORD_RGB;
        endcase
        case (cfg_map)
            3'd0, 3'd1, 3'd2, 3'd3, 3'd4: cfg_d.map = map_e'(cfg_map);
            default:                      cfg_d.map = MAP_RGB;
        endcase
        case (cfg_depth)
            3'd0, 3'd1, 3'd2, 3'd3: cfg_d.depth = depth_e'(cfg_depth);
            default:                cfg_d.depth = DEP_8;
        endcase
        cfg_d.in_swap = cfg_in_swap;
        case (fmt_e'(cfg_fmt))
            FMT_YUV444: begin
                cfg_d.in_swap = 1'b0;
                cfg_d.order   = ORD_BGR;
            end
            FMT_YUV422: begin
                cfg_d.in_swap = 1'b1;
                cfg_d.order   = ORD_RGB;
            end
            default: ;
        endcase
    end

    // Hold settings; load only during soft reset.
    always_ff @(posedge clk) begin
        if (!rst_n)        cfg_q <= cfg_default();
        else if (soft_rst) cfg_q <= cfg_d;
    end

    AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !soft_rst |=> $stable(cfg_q)); // R3
endmodule

// File: rtl/pof_swizzle.sv
// Stage 1: red/blue input exchange, six-way component reorder, per-position
// clamping (lane 1 luma window, lanes 0 and 2 chroma window) and pixel parity.
// Assumes settings are stable while soft_rst is low.
module pof_swizzle
    import pof_pkg::*;
(
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             soft_rst,
    input  fmt_cfg_t                         cfg,
    input  logic                             pix_de,
    input  logic [PIX_W-1:0]                 pix_data,
    output logic                             s1_de,
    output logic [N_LANES-1:0][COMP_W-1:0]   s1_lanes,
    output logic                             s1_odd
);
    logic [COMP_W-1:0]                 in_r, in_g, in_b;
    logic [COMP_W-1:0]                 sw_r, sw_b;
    logic [N_LANES-1:0][COMP_W-1:0]    ordered;
    logic [N_LANES-1:0][COMP_W-1:0]    clamped;
    logic                              prev_de, prev_odd, cur_odd;

    assign in_r = pix_data[3*COMP_W-1 -: COMP_W];
    assign in_g = pix_data[2*COMP_W-1 -: COMP_W];
    assign in_b = pix_data[COMP_W-1:0];
    assign sw_r = cfg.in_swap ? in_b : in_r;
    assign sw_b = cfg.in_swap ? in_r : in_b;

    // Place components on lanes {2,1,0} according to the order setting.
    always_comb begin
        case (cfg.order)
            ORD_GBR: ordered = {in_g, sw_b, sw_r};
            ORD_BRG: ordered = {sw_b, sw_r, in_g};
            ORD_RBG: ordered = {sw_r, sw_b, in_g};
            ORD_GRB: ordered = {in_g, sw_r, sw_b};
            ORD_BGR: ordered = {sw_b, in_g, sw_r};
            default: ordered = {sw_r, in_g, sw_b};
        endcase
    end

    // Clamp each lane into the window belonging to its position.
    for (genvar i = 0; i < N_LANES; i++) begin : g_clamp
        localparam bit IS_LUMA = (i == 1);
        logic [COMP_W-1:0] lo, hi;
        assign lo = IS_LUMA ? cfg.y_lo : cfg.c_lo;
        assign hi = IS_LUMA ? cfg.y_hi : cfg.c_hi;
        assign clamped[i] = (ordered[i] < lo) ? lo :
                            (ordered[i] > hi) ? hi : ordered[i];
    end

    // Parity restarts after any blank cycle.
    assign cur_odd = prev_de ? ~prev_odd : 1'b0;

    // Stage-1 pipeline register and parity tracking.
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst) begin
            s1_de    <= 1'b0;
            s1_lanes <= '0;
            s1_odd   <= 1'b0;
            prev_de  <= 1'b0;
            prev_odd <= 1'b0;
        end else begin
            s1_de    <= pix_de;
            s1_lanes <= clamped;
            s1_odd   <= cur_odd;
            prev_de  <= pix_de;
            if (pix_de) prev_odd <= cur_odd;
        end
    end

    AST_LUMA_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        (s1_de && cfg.y_lo <= cfg.y_hi) |-> (s1_lanes[1] >= cfg.y_lo && s1_lanes[1] <= cfg.y_hi)); // R7
    AST_CHROMA_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        (s1_de && cfg.c_lo <= cfg.c_hi) |-> (s1_lanes[0] >= cfg.c_lo && s1_lanes[0] <= cfg.c_hi &&
                                            s1_lanes[2] >= cfg.c_lo && s1_lanes[2] <= cfg.c_hi)); // R7
    AST_PARITY_START: assert property (@(posedge clk) disable iff (!rst_n)
        (s1_de && !$past(s1_de)) |-> !s1_odd); // R9
    AST_PARITY_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
        (s1_de && $past(s1_de)) |-> (s1_odd != $past(s1_odd))); // R9
endmodule

// File: rtl/pof_pack.sv
// Stage 2: luma/chroma packing with parity-driven chroma choice, then placement
// of every component on its 16-bit lane at the selected depth. Blank beats
// output zero. Assumes lane 1 holds luma and lanes 0/2 hold chroma.
module pof_pack
    import pof_pkg::*;
(
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             soft_rst,
    input  fmt_cfg_t                         cfg,
    input  logic                             s1_de,
    input  logic [N_LANES-1:0][COMP_W-1:0]   s1_lanes,
    input  logic                             s1_odd,
    output logic                             out_de,
    output logic [OUT_W-1:0]                 out_data
);
    logic [COMP_W-1:0]                 luma, chroma;
    logic [N_LANES-1:0][COMP_W-1:0]    placed;
    logic [N_LANES-1:0][LANE_W-1:0]    lane_out;

    // Put a component on a lane at the chosen depth, keeping its top bits.
    function automatic logic [LANE_W-1:0] to_lane(logic [COMP_W-1:0] v, depth_e d);
        case (d)
            DEP_10:  return LANE_W'(v[COMP_W-1 -: 10]);
            DEP_12:  return LANE_W'(v);
            DEP_16:  return {v, {(LANE_W-COMP_W){1'b0}}};
            default: return LANE_W'(v[COMP_W-1 -: 8]);
        endcase
    endfunction

    assign luma = s1_lanes[1];

    // Pick the chroma lane for this beat from parity and mapping phase.
    always_comb begin
        if (cfg.map == MAP_CY || cfg.map == MAP_YC)
            chroma = s1_odd ? s1_lanes[0] : s1_lanes[2];
        else
            chroma = s1_odd ? s1_lanes[2] : s1_lanes[0];
    end

    // Arrange samples across the lanes for the mapping mode.
    always_comb begin
        case (cfg.map)
            MAP_CYCY, MAP_CY: placed = {chroma, luma, {COMP_W{1'b0}}};
            MAP_YCYC, MAP_YC: placed = {luma, chroma, {COMP_W{1'b0}}};
            default:          placed = s1_lanes;
        endcase
    end

    for (genvar i = 0; i < N_LANES; i++) begin : g_lane
        assign lane_out[i] = to_lane(placed[i], cfg.depth);
    end

    // Output register; blank beats carry zero.
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst) begin
            out_de   <= 1'b0;
            out_data <= '0;
        end else begin
            out_de   <= s1_de;
            out_data <= s1_de ? lane_out : '0;
        end
    end

    AST_BLANK_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !out_de |-> (out_data == '0)); // R2
    AST_PACK_PAD: assert property (@(posedge clk) disable iff (!rst_n)
        (out_de && cfg.map != MAP_RGB) |-> (out_data[LANE_W-1:0] == '0)); // R8
    AST_DEPTH8_HEADROOM: assert property (@(posedge clk) disable iff (!rst_n)
        (out_de && cfg.depth == DEP_8) |-> (out_data[LANE_W-1:8] == '0 &&
            out_data[2*LANE_W-1:LANE_W+8] == '0 && out_data[3*LANE_W-1:2*LANE_W+8] == '0)); // R10
endmodule

// File: rtl/pixel_out_formatter.sv
// Top: settings capture, stage-1 swizzle/clamp and stage-2 pack/depth.
// Two-cycle latency from pix_* to out_*; soft_rst flushes both stages.
module pixel_out_formatter
    import pof_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              soft_rst,
    input  logic [1:0]        cfg_fmt,
    input  logic              cfg_in_swap,
    input  logic [2:0]        cfg_order,
    input  logic [2:0]        cfg_map,
    input  logic [2:0]        cfg_depth,
    input  logic [11:0]       cfg_y_lo,
    input  logic [11:0]       cfg_y_hi,
    input  logic [11:0]       cfg_c_lo,
    input  logic [11:0]       cfg_c_hi,
    input  logic              pix_de,
    input  logic [35:0]       pix_data,
    output logic              out_de,
    output logic [47:0]       out_data
);
    fmt_cfg_t                          cfg_q;
    logic                              s1_de, s1_odd;
    logic [N_LANES-1:0][COMP_W-1:0]    s1_lanes;
    logic [1:0]                        run_age;

    pof_cfg u_cfg (
        .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
        .cfg_fmt(cfg_fmt), .cfg_in_swap(cfg_in_swap), .cfg_order(cfg_order),
        .cfg_map(cfg_map), .cfg_depth(cfg_depth),
        .cfg_y_lo(cfg_y_lo), .cfg_y_hi(cfg_y_hi), .cfg_c_lo(cfg_c_lo), .cfg_c_hi(cfg_c_hi),
        .cfg_q(cfg_q)
    );

    pof_swizzle u_swizzle (
        .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .cfg(cfg_q),
        .pix_de(pix_de), .pix_data(pix_data),
        .s1_de(s1_de), .s1_lanes(s1_lanes), .s1_odd(s1_odd)
    );

    pof_pack u_pack (
        .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .cfg(cfg_q),
        .s1_de(s1_de), .s1_lanes(s1_lanes), .s1_odd(s1_odd),
        .out_de(out_de), .out_data(out_data)
    );

    // Cycles of uninterrupted running, saturating at 2, for the latency check.
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst)    run_age <= 2'd0;
        else if (run_age != 2'd2)  run_age <= run_age + 2'd1;
    end

    AST_DE_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
        (run_age == 2'd2) |-> (out_de == $past(pix_de, 2))); // R2
    AST_SOFT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> !out_de); // R3
endmodule

// File: tb/pixel_out_formatter_bench.sv
`timescale 1ns/1ps
module pixel_out_formatter_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        soft_rst = 1'b0;
    logic [1:0]  cfg_fmt = '0;
    logic        cfg_in_swap = 1'b0;
    logic [2:0]  cfg_order = '0, cfg_map = '0, cfg_depth = '0;
    logic [11:0] cfg_y_lo = '0, cfg_y_hi = '0, cfg_c_lo = '0, cfg_c_hi = '0;
    logic        pix_de = 1'b0;
    logic [35:0] pix_data = '0;
    logic        out_de;
    logic [47:0] out_data;

    int n_chk = 0, n_fail = 0;

    // Model of the settings in force.
    int m_fmt = 0, m_swap = 0, m_order = 0, m_map = 0, m_depth = 0;
    logic [11:0] m_ylo = 12'h010, m_yhi = 12'hFE0, m_clo = 12'h010, m_chi = 12'hFE0;

    logic [35:0] st_px [16];
    bit          st_de [16];
    int          st_n;

    always #4 clk = ~clk;

    pixel_out_formatter u_pixel_out_formatter (
        .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
        .cfg_fmt(cfg_fmt), .cfg_in_swap(cfg_in_swap), .cfg_order(cfg_order),
        .cfg_map(cfg_map), .cfg_depth(cfg_depth),
        .cfg_y_lo(cfg_y_lo), .cfg_y_hi(cfg_y_hi), .cfg_c_lo(cfg_c_lo), .cfg_c_hi(cfg_c_hi),
        .pix_de(pix_de), .pix_data(pix_data), .out_de(out_de), .out_data(out_data)
    );

    task automatic check(input string tag, input logic [47:0] got, input logic [47:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, got, exp);
        end
    endtask

    function automatic logic [11:0] clampv(logic [11:0] v, logic [11:0] lo, logic [11:0] hi);
        if (v < lo) return lo;
        if (v > hi) return hi;
        return v;
    endfunction

    function automatic logic [15:0] deplane(logic [11:0] v);
        case (m_depth)
            1:       return {6'h0, v[11:2]};
            2:       return {4'h0, v};
            3:       return {v, 4'h0};
            default: return {8'h0, v[11:4]};
        endcase
    endfunction

    // Expected output word from the requirements.
    function automatic logic [47:0] model(logic [35:0] px, bit odd);
        logic [11:0] r, g, b, t, l2, l1, l0, ch, p2, p1, p0;
        int sw, od;
        r = px[35:24]; g = px[23:12]; b = px[11:0];
        sw = m_swap; od = m_order;
        if (m_fmt == 1) begin sw = 0; od = 5; end
        else if (m_fmt == 2) begin sw = 1; od = 0; end
        if (sw != 0) begin t = r; r = b; b = t; end
        case (od)
            1: begin l2 = g; l1 = b; l0 = r; end
            2: begin l2 = b; l1 = r; l0 = g; end
            3: begin l2 = r; l1 = b; l0 = g; end
            4: begin l2 = g; l1 = r; l0 = b; end
            5: begin l2 = b; l1 = g; l0 = r; end
            default: begin l2 = r; l1 = g; l0 = b; end
        endcase
        l2 = clampv(l2, m_clo, m_chi);
        l1 = clampv(l1, m_ylo, m_yhi);
        l0 = clampv(l0, m_clo, m_chi);
        if (m_map == 1 || m_map == 2) ch = odd ? l2 : l0;
        else ch = odd ? l0 : l2;
        case (m_map)
            1, 3: begin p2 = ch; p1 = l1; p0 = 12'h0; end
            2, 4: begin p2 = l1; p1 = ch; p0 = 12'h0; end
            default: begin p2 = l2; p1 = l1; p0 = l0; end
        endcase
        return {deplane(p2), deplane(p1), deplane(p0)};
    endfunction

    // Load settings under soft reset, then scramble the inputs (must be ignored).
    task automatic do_config(input int fmt, input int sw, input int ord, input int map, input int dep,
                             input logic [11:0] ylo, input logic [11:0] yhi,
                             input logic [11:0] clo, input logic [11:0] chi);
        @(negedge clk);
        cfg_fmt = 2'(fmt); cfg_in_swap = 1'(sw); cfg_order = 3'(ord); cfg_map = 3'(map);
        cfg_depth = 3'(dep); cfg_y_lo = ylo; cfg_y_hi = yhi; cfg_c_lo = clo; cfg_c_hi = chi;
        soft_rst = 1'b1; pix_de = 1'b1; pix_data = 36'h5A5_A5A_5A5;
        @(negedge clk);
        @(negedge clk);
        check("R3 idle during soft reset", {47'h0, out_de}, 48'h0);
        soft_rst = 1'b0; pix_de = 1'b0; pix_data = '0;
        cfg_fmt = ~cfg_fmt; cfg_in_swap = ~cfg_in_swap; cfg_order = ~cfg_order;
        cfg_map = cfg_map + 3'd1; cfg_depth = cfg_depth + 3'd1;
        cfg_y_lo = 12'h7FF; cfg_y_hi = 12'h800; cfg_c_lo = 12'h7FF; cfg_c_hi = 12'h800;
        m_fmt = fmt; m_swap = sw; m_order = ord; m_map = map; m_depth = dep;
        m_ylo = ylo; m_yhi = yhi; m_clo = clo; m_chi = chi;
        @(negedge clk);
    endtask

    // Drive st_* and compare each beat two cycles later.
    task automatic run_stream(input string tag);
        bit odd [16];
        for (int i = 0; i < st_n; i++)
            odd[i] = (i > 0 && st_de[i-1]) ? !odd[i-1] : 1'b0;
        for (int i = 0; i < st_n + 2; i++) begin
            @(negedge clk);
            if (i >= 2) begin
                check({tag, " de"}, {47'h0, out_de}, {47'h0, st_de[i-2]});
                check({tag, " data"}, out_data, st_de[i-2] ? model(st_px[i-2], odd[i-2]) : 48'h0);
            end
            if (i < st_n) begin pix_de = st_de[i]; pix_data = st_px[i]; end
            else begin pix_de = 1'b0; pix_data = '0; end
        end
    endtask

    task automatic load_basic();
        st_n = 4;
        st_px[0] = 36'h123_456_789; st_px[1] = 36'hABC_DEF_012;
        st_px[2] = 36'h005_FFF_800; st_px[3] = 36'hF0F_0F0_3C3;
        for (int i = 0; i < 4; i++) st_de[i] = 1'b1;
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check("R1 reset out_de", {47'h0, out_de}, 48'h0);
        check("R1 reset out_data", out_data, 48'h0);
        rst_n = 1'b1;
        @(negedge clk);
        st_n = 1; st_px[0] = 36'h005_FFF_123; st_de[0] = 1'b1;
        run_stream("R1 default settings");
        check("R1 default literal", model(36'h005_FFF_123, 1'b0), {16'h0001, 16'h00FE, 16'h0012});
    endtask

    task automatic t_latency();
        do_config(0, 0, 0, 0, 2, 12'h000, 12'hFFF, 12'h000, 12'hFFF);
        st_n = 7;
        st_de[0] = 1; st_de[1] = 0; st_de[2] = 1; st_de[3] = 1; st_de[4] = 0; st_de[5] = 0; st_de[6] = 1;
        for (int i = 0; i < 7; i++) st_px[i] = 36'(i * 36'h111_222_333 + 36'h0AB);
        run_stream("R2 latency and blanking");
    endtask

    task automatic t_soft();
        do_config(0, 0, 5, 0, 2, 12'h000, 12'hFFF, 12'h000, 12'hFFF);
        load_basic();
        run_stream("R3 scrambled inputs ignored");
    endtask

    task automatic t_orders();
        for (int sw = 0; sw < 2; sw++)
            for (int ord = 0; ord < 8; ord++) begin
                do_config(0, sw, ord, 0, 2, 12'h000, 12'hFFF, 12'h000, 12'hFFF);
                st_n = 2; st_px[0] = 36'h111_222_333; st_px[1] = 36'hA0B_C0D_E0F;
                st_de[0] = 1; st_de[1] = 1;
                run_stream(sw != 0 ? "R4 R5 swap+order" : "R5 order");
            end
    endtask

    task automatic t_formats();
        for (int f = 0; f < 4; f++) begin
            do_config(f, 0, 1, 0, 2, 12'h000, 12'hFFF, 12'h000, 12'hFFF);
            load_basic();
            run_stream("R6 format override");
        end
    endtask

    task automatic t_clamp();
        for (int ord = 0; ord < 2; ord++) begin
            do_config(0, 0, ord, 0, 2, 12'h100, 12'h800, 12'h200, 12'h300);
            st_n = 4;
            st_px[0] = 36'h000_000_000; st_px[1] = 36'hFFF_FFF_FFF;
            st_px[2] = 36'h250_400_2FF; st_px[3] = 36'h1FF_0FF_801;
            for (int i = 0; i < 4; i++) st_de[i] = 1'b1;
            run_stream("R7 clamp windows");
        end
    endtask

    task automatic t_pack();
        for (int mp = 0; mp < 8; mp++) begin
            do_config(0, 0, 0, mp, 2, 12'h000, 12'hFFF, 12'h000, 12'hFFF);
            st_n = 7;
            st_de[0] = 1; st_de[1] = 1; st_de[2] = 1; st_de[3] = 0;
            st_de[4] = 1; st_de[5] = 1; st_de[6] = 1;
            for (int i = 0; i < 7; i++)
                st_px[i] = {12'(12'hC00 + i), 12'(12'h500 + i), 12'(12'h0B0 + i)};
            run_stream("R8 R9 packing and chroma phase");
        end
    endtask

    task automatic t_depth();
        for (int d = 0; d < 8; d++) begin
            do_config(0, 0, 0, 0, d, 12'h000, 12'hFFF, 12'h000, 12'hFFF);
            load_basic();
            run_stream("R10 depth");
        end
    endtask

    initial begin
        #1200000;
        n_fail++;
        $display("FAIL R2 watchdog expired actual=running expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        t_reset();
        t_latency();
        t_soft();
        t_orders();
        t_formats();
        t_clamp();
        t_pack();
        t_depth();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule